// File: doc/BRIEF.md
# Flash Byte Program and Verify Engine

This engine writes a run of bytes into one 64 KB block of a byte-wide flash part and then checks them by reading them back. A caller gives a start address and a byte count with a one-cycle start pulse. The engine clips the run so that it never crosses the end of the block. It fetches each byte from a source port, selects the byte lane, and issues the program command followed by the data to the word-aligned address. It then requests status and polls the ready flag.

A status poll that runs too long is cleared and the same byte is retried. A byte that reports a program error is cleared, given a settle pause and retried, but only while the deadline for the whole block has not passed. Once the block deadline has passed, the run ends with an error code. When every byte has been accepted, the engine waits a settle period, requests every byte from the source a second time and compares it with what the flash returns. The caller receives the number of bytes written, zero after a readback mismatch (the cue to erase and try again), or minus two after a deadline failure.

All timing windows are counted in clock cycles and set by parameters. Erasing the block and arbitrating for the flash bus are outside this block.

Top module: `flash_prog_verify`

## Requirements
- R1: On start, the byte count is clipped to min(count, 0x10000 - address[15:0]), and a successful run returns the clipped count on `result_o` with a one-cycle `done_o`.
- R2: For each byte, the lane register is loaded with address bits 1:0 (`lane_wr_o`). The next cycle writes 0x40 to the byte address with bits 1:0 cleared, and the cycle after that writes the data byte to the same address.
- R3: The cycle after the data write, 0x70 is written to `CMD_ADDR`. Reads of `CMD_ADDR` then poll status bit 7 (1 = ready).
- R4: If ready is not seen within `BYTE_TMO` poll cycles, 0x50 is written to `CMD_ADDR` and the same byte is programmed again, starting from the lane load.
- R5: Each time status shows ready, the following cycle writes 0xFF to `CMD_ADDR` to return the part to read mode.
- R6: If status bit 4 is set when ready, 0x50 is written to `CMD_ADDR`. While the block deadline `BLOCK_DL` (counted from start) has not expired, the engine waits `SETTLE_CYC` cycles and programs the same byte again.
- R7: If a program error is cleared after the block deadline has expired, the run ends with `result_o` = -2 in two's complement.
- R8: After the last byte, the engine waits `SETTLE_CYC` cycles and reads every programmed address. Any readback that differs from the source byte ends the run with result 0.
- R9: A clipped count of zero ends the run on the next cycle with result 0 and no flash, lane or source activity.
- R10: Bytes are taken from the source on `src_valid_i && src_ready_o` for index `src_idx_o`. The verify pass requests the same indices again from 0, and `src_idx_o` holds while the source stalls.
- R11: During reset and while idle, `busy_o`, `done_o`, every flash strobe, `lane_wr_o` and `src_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| addr_i | input | ADDR_W | First byte address |
| count_i | input | BLK_W+1 | Requested byte count |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | BLK_W+2 | Bytes written, 0, or -2 |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte for `src_idx_o` |
| src_ready_o | output | 1 | Engine takes a byte |
| src_idx_o | output | BLK_W | Index of the requested byte |
| lane_wr_o | output | 1 | Load lane register |
| lane_o | output | 2 | Byte lane value |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, valid in the cycle of `fl_rd_o` |

## Verification
The bench targets several corner cases:
- A run that starts a few bytes short of the block end, and a single byte on the last address. An engine that clips wrongly writes into the next block or reports the wrong count.
- A status poll held busy beyond the byte window. An engine that mishandles the timeout hangs, or skips the clear and the retry.
- Program errors that go away, and errors that never go away. An engine that gets these wrong gives up too early or never returns -2.
- A corrupted readback, which must give zero rather than the count.
- A zero-length run, which must produce no bus traffic at all.

The 0xFF and 0x50 writes are counted in every case to expose missing or extra restores and clears.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LANE, S_PCMD, S_PDATA, S_SREQ, S_POLL, S_TCLR,
    S_RDMODE, S_ECLR, S_RWAIT, S_VWAIT, S_VFETCH, S_VCMP, S_DONE
  } state_e;

  localparam logic [7:0] CMD_PROG = 8'h40;
  localparam logic [7:0] CMD_STAT = 8'h70;
  localparam logic [7:0] CMD_CLR  = 8'h50;
  localparam logic [7:0] CMD_READ = 8'hFF;
  localparam int RDY_BIT = 7;
  localparam int ERR_BIT = 4;
endpackage

// File: rtl/fpv_clip.sv
module fpv_clip #(
  parameter int BLK_W = 16,
  localparam int CNT_W = BLK_W + 1
) (
  input  logic [BLK_W-1:0] off_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] BLK_BYTES = CNT_W'(1) << BLK_W;
  logic [CNT_W-1:0] room;

  assign room  = BLK_BYTES - {1'b0, off_i};
  assign cnt_o = (count_i > room) ? room : count_i;
endmodule

// File: rtl/fpv_timer.sv
module fpv_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  localparam int RAW_W = $clog2(64'(LIMIT) + 64'd1);
  localparam int W = (RAW_W < 1) ? 1 : RAW_W;
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i && !exp_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq
  import fpv_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BLK_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(32'h8000),
  localparam int CNT_W = BLK_W + 1,
  localparam int RES_W = BLK_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic [BLK_W-1:0]  src_idx_o,
  output logic              lane_wr_o,
  output logic [1:0]        lane_o,
  output logic              fl_wr_o,
  output logic              fl_rd_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              byte_clr_o,
  output logic              byte_en_o,
  input  logic              byte_exp_i,
  output logic              blk_clr_o,
  output logic              blk_en_o,
  input  logic              blk_exp_i,
  output logic              set_clr_o,
  output logic              set_en_o,
  input  logic              set_exp_i
);
  localparam logic [RES_W-1:0] RES_FAIL = ~RES_W'(1);  // -2

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, idx_q, idx_d;
  logic [7:0]        data_q, data_d;
  logic              err_q, err_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic [ADDR_W-1:0] byte_addr;
  logic              last_byte;

  assign byte_addr = base_q + ADDR_W'(idx_q);
  assign last_byte = (idx_q + CNT_W'(1)) == cnt_q;

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign result_o    = res_q;
  assign src_ready_o = (state_q == S_FETCH) || (state_q == S_VFETCH);
  assign src_idx_o   = idx_q[BLK_W-1:0];
  assign lane_wr_o   = (state_q == S_LANE);
  assign lane_o      = byte_addr[1:0];
  assign byte_clr_o  = (state_q != S_POLL);
  assign byte_en_o   = (state_q == S_POLL);
  assign blk_clr_o   = (state_q == S_IDLE);
  assign blk_en_o    = busy_o;
  assign set_en_o    = (state_q == S_RWAIT) || (state_q == S_VWAIT);
  assign set_clr_o   = !set_en_o;

  always_comb begin
    fl_wr_o    = 1'b0;
    fl_rd_o    = 1'b0;
    fl_addr_o  = CMD_ADDR;
    fl_wdata_o = CMD_READ;
    unique case (state_q)
      S_PCMD:   begin fl_wr_o = 1'b1; fl_addr_o = {byte_addr[ADDR_W-1:2], 2'b00}; fl_wdata_o = CMD_PROG; end
      S_PDATA:  begin fl_wr_o = 1'b1; fl_addr_o = {byte_addr[ADDR_W-1:2], 2'b00}; fl_wdata_o = data_q; end
      S_SREQ:   begin fl_wr_o = 1'b1; fl_wdata_o = CMD_STAT; end
      S_TCLR,
      S_ECLR:   begin fl_wr_o = 1'b1; fl_wdata_o = CMD_CLR; end
      S_RDMODE: fl_wr_o = 1'b1;
      S_POLL:   fl_rd_o = 1'b1;
      S_VCMP:   begin fl_rd_o = 1'b1; fl_addr_o = byte_addr; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    err_d   = err_q;
    res_d   = res_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        base_d = base_i;
        cnt_d  = cnt_i;
        idx_d  = '0;
        if (cnt_i == '0) begin
          res_d   = '0;
          state_d = S_DONE;
        end else begin
          state_d = S_FETCH;
        end
      end
      S_FETCH: if (src_valid_i) begin
        data_d  = src_data_i;
        state_d = S_LANE;
      end
      S_LANE:  state_d = S_PCMD;
      S_PCMD:  state_d = S_PDATA;
      S_PDATA: state_d = S_SREQ;
      S_SREQ:  state_d = S_POLL;
      S_POLL: begin
        if (fl_rdata_i[RDY_BIT]) begin
          err_d   = fl_rdata_i[ERR_BIT];
          state_d = S_RDMODE;
        end else if (byte_exp_i) begin
          state_d = S_TCLR;
        end
      end
      S_TCLR: state_d = S_LANE;
      S_RDMODE: begin
        if (err_q) state_d = S_ECLR;
        else if (last_byte) begin
          idx_d   = '0;
          state_d = S_VWAIT;
        end else begin
          idx_d   = idx_q + CNT_W'(1);
          state_d = S_FETCH;
        end
      end
      S_ECLR: begin
        if (blk_exp_i) begin
          res_d   = RES_FAIL;
          state_d = S_DONE;
        end else begin
          state_d = S_RWAIT;
        end
      end
      S_RWAIT: if (set_exp_i) state_d = S_LANE;
      S_VWAIT: if (set_exp_i) state_d = S_VFETCH;
      S_VFETCH: if (src_valid_i) begin
        data_d  = src_data_i;
        state_d = S_VCMP;
      end
      S_VCMP: begin
        if (fl_rdata_i != data_q) begin
          res_d   = '0;
          state_d = S_DONE;
        end else if (last_byte) begin
          res_d   = RES_W'(cnt_q);
          state_d = S_DONE;
        end else begin
          idx_d   = idx_q + CNT_W'(1);
          state_d = S_VFETCH;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      err_q   <= err_d;
      res_q   <= res_d;
    end
  end
endmodule

// File: rtl/flash_prog_verify.sv
module flash_prog_verify #(
  parameter int ADDR_W = 22,
  parameter int BLK_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(32'h8000),
  parameter int unsigned BYTE_TMO = 100_000_000,
  parameter int unsigned BLOCK_DL = 32'd3_000_000_000,
  parameter int unsigned SETTLE_CYC = 1_000_000,
  localparam int CNT_W = BLK_W + 1,
  localparam int RES_W = BLK_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic [BLK_W-1:0]  src_idx_o,
  output logic              lane_wr_o,
  output logic [1:0]        lane_o,
  output logic              fl_wr_o,
  output logic              fl_rd_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i
);
  logic [CNT_W-1:0] clip_cnt;
  logic byte_clr, byte_en, byte_exp;
  logic blk_clr, blk_en, blk_exp;
  logic set_clr, set_en, set_exp;

  fpv_clip #(.BLK_W(BLK_W)) u_clip (
    .off_i  (addr_i[BLK_W-1:0]),
    .count_i(count_i),
    .cnt_o  (clip_cnt)
  );

  fpv_timer #(.LIMIT(BYTE_TMO)) u_byte_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(byte_clr), .en_i(byte_en), .exp_o(byte_exp)
  );

  fpv_timer #(.LIMIT(BLOCK_DL)) u_blk_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(blk_clr), .en_i(blk_en), .exp_o(blk_exp)
  );

  fpv_timer #(.LIMIT(SETTLE_CYC)) u_set_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(set_clr), .en_i(set_en), .exp_o(set_exp)
  );

  fpv_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CMD_ADDR(CMD_ADDR)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (addr_i),
    .cnt_i      (clip_cnt),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .src_valid_i(src_valid_i),
    .src_data_i (src_data_i),
    .src_ready_o(src_ready_o),
    .src_idx_o  (src_idx_o),
    .lane_wr_o  (lane_wr_o),
    .lane_o     (lane_o),
    .fl_wr_o    (fl_wr_o),
    .fl_rd_o    (fl_rd_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_rdata_i (fl_rdata_i),
    .byte_clr_o (byte_clr),
    .byte_en_o  (byte_en),
    .byte_exp_i (byte_exp),
    .blk_clr_o  (blk_clr),
    .blk_en_o   (blk_en),
    .blk_exp_i  (blk_exp),
    .set_clr_o  (set_clr),
    .set_en_o   (set_en),
    .set_exp_i  (set_exp)
  );
endmodule

// File: rtl/flash_prog_verify_chk.sv
module flash_prog_verify_chk #(
  parameter int ADDR_W = 22,
  parameter int BLK_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(32'h8000),
  localparam int RES_W = BLK_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [RES_W-1:0]  result_o,
  input logic              src_valid_i,
  input logic              src_ready_o,
  input logic [BLK_W-1:0]  src_idx_o,
  input logic              lane_wr_o,
  input logic              fl_wr_o,
  input logic              fl_rd_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic [7:0]        fl_rdata_i
);
  // status-mode tracker built from the bus alone
  logic stat_mode;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_mode <= 1'b0;
    else if (fl_wr_o && fl_addr_o == CMD_ADDR && fl_wdata_o == 8'h70) stat_mode <= 1'b1;
    else if (fl_wr_o && fl_addr_o == CMD_ADDR && fl_wdata_o == 8'hFF) stat_mode <= 1'b0;
  end

  p_prog_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_wr_o |=> fl_wr_o && fl_wdata_o == 8'h40 && fl_addr_o[1:0] == 2'b00);

  p_prog_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lane_wr_o) |=> fl_wr_o && fl_addr_o == $past(fl_addr_o));

  p_stat_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lane_wr_o, 2) |=> fl_wr_o && fl_addr_o == CMD_ADDR && fl_wdata_o == 8'h70);

  p_read_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_mode && fl_rd_o && fl_rdata_i[7] |=> fl_wr_o && fl_addr_o == CMD_ADDR && fl_wdata_o == 8'hFF);

  p_fail_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o[RES_W-1] |-> result_o == ~RES_W'(1));

  p_done_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  p_src_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o && !src_valid_i |=> src_ready_o && $stable(src_idx_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !fl_wr_o && !fl_rd_o && !src_ready_o && !lane_wr_o && !done_o);
endmodule

bind flash_prog_verify flash_prog_verify_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
  .src_idx_o(src_idx_o), .lane_wr_o(lane_wr_o), .fl_wr_o(fl_wr_o),
  .fl_rd_o(fl_rd_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
  .fl_rdata_i(fl_rdata_i)
);

// File: tb/flash_prog_verify_tb_top.sv
module flash_prog_verify_tb_top;
  localparam int ADDR_W = 22;
  localparam int BLK_W  = 16;
  localparam int CNT_W  = 17;
  localparam int RES_W  = 18;
  localparam logic [ADDR_W-1:0] CMD_A = 22'h008000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  count;
  logic              busy, done;
  logic [RES_W-1:0]  result;
  logic              src_valid;
  logic [7:0]        src_data;
  logic              src_ready;
  logic [BLK_W-1:0]  src_idx;
  logic              lane_wr;
  logic [1:0]        lane;
  logic              fl_wr, fl_rd;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_wdata;
  logic [7:0]        fl_rdata;

  flash_prog_verify #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CMD_ADDR(CMD_A),
    .BYTE_TMO(20), .BLOCK_DL(1500), .SETTLE_CYC(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .count_i(count),
    .busy_o(busy), .done_o(done), .result_o(result),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .src_idx_o(src_idx), .lane_wr_o(lane_wr), .lane_o(lane),
    .fl_wr_o(fl_wr), .fl_rd_o(fl_rd), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata)
  );

  function automatic logic [7:0] pat(input logic [BLK_W-1:0] i);
    return 8'((32'(i) * 37) + 90);
  endfunction

  assign src_valid = 1'b1;
  assign src_data  = pat(src_idx);

  // flash model, evaluated away from the active edge
  logic [7:0] mem [int];
  logic       stat_mode, errflag, expect_data;
  logic [1:0] m_lane;
  int busy_cnt, stuck_left, err_left, corrupt_addr;
  int n_ff, n_clr, n_70, n_wr;

  task automatic model_init(input int stuck, input int errs, input int corrupt);
    mem.delete();
    stat_mode = 1'b0; errflag = 1'b0; expect_data = 1'b0; m_lane = 2'b00;
    busy_cnt = 0; stuck_left = stuck; err_left = errs; corrupt_addr = corrupt;
    n_ff = 0; n_clr = 0; n_70 = 0; n_wr = 0;
  endtask

  always @(negedge clk) begin
    if (stat_mode) fl_rdata = {busy_cnt == 0, 2'b00, errflag, 4'b0000};
    else fl_rdata = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF;
    if (lane_wr) m_lane = lane;
    if (fl_rd && stat_mode && busy_cnt > 0) busy_cnt--;
    if (fl_wr) begin
      n_wr++;
      if (expect_data) begin
        int a;
        a = int'({fl_addr[ADDR_W-1:2], m_lane});
        expect_data = 1'b0;
        if (err_left > 0) begin err_left--; errflag = 1'b1; end
        else mem[a] = (a == corrupt_addr) ? (fl_wdata ^ 8'h01) : fl_wdata;
      end else if (fl_addr != CMD_A && fl_wdata == 8'h40) begin
        expect_data = 1'b1;
      end else if (fl_addr == CMD_A) begin
        case (fl_wdata)
          8'h70: begin
            stat_mode = 1'b1; n_70++;
            busy_cnt = (stuck_left > 0) ? 1000 : 2;
            if (stuck_left > 0) stuck_left--;
          end
          8'hFF: begin stat_mode = 1'b0; n_ff++; end
          8'h50: begin errflag = 1'b0; n_clr++; end
          default: ;
        endcase
      end
    end
  end

  int n_total = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [21:0] a;
    logic [16:0] c;
    logic        stuck;
    logic [15:0] errs;
    logic [7:0]  corrupt1;  // corrupted index + 1, 0 = none
    logic [17:0] exp;
    logic [7:0]  exp_ff;    // 0xFF = not checked
    logic [7:0]  exp_clr;   // 0xFF = not checked
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{22'h010003, 17'd5,     1'b0, 16'd0,      8'd0, 18'd5,      8'd5,   8'd0},
    '{22'h02FFFA, 17'd20,    1'b0, 16'd0,      8'd0, 18'd6,      8'd6,   8'd0},
    '{22'h000000, 17'd4,     1'b1, 16'd0,      8'd0, 18'd4,      8'd4,   8'd1},
    '{22'h030101, 17'd3,     1'b0, 16'd2,      8'd0, 18'd3,      8'd5,   8'd2},
    '{22'h040010, 17'd3,     1'b0, 16'hFFFF,   8'd0, 18'h3FFFE,  8'hFF,  8'hFF},
    '{22'h050020, 17'd6,     1'b0, 16'd0,      8'd4, 18'd0,      8'd6,   8'd0},
    '{22'h060000, 17'd0,     1'b0, 16'd0,      8'd0, 18'd0,      8'd0,   8'd0},
    '{22'h07FFFF, 17'd1,     1'b0, 16'd0,      8'd0, 18'd1,      8'd1,   8'd0},
    '{22'h08FFFE, 17'h10000, 1'b0, 16'd0,      8'd0, 18'd2,      8'd2,   8'd0}
  };

  function automatic string tag_of(input int v);
    case (v)
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    start = 1'b0; addr = '0; count = '0;
    model_init(0, 0, -1);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !src_ready && !fl_wr && !fl_rd && !lane_wr, "R11 reset",
        {busy, done, src_ready, fl_wr, fl_rd, lane_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !fl_wr && !fl_rd, "R11 idle", {busy, fl_wr, fl_rd}, 0);

    for (int v = 0; v < 9; v++) begin
      vec_t t;
      int w;
      int bad;
      t = VEC[v];
      model_init(int'(t.stuck), int'(t.errs),
                 (t.corrupt1 == 0) ? -1 : int'(t.a) + int'(t.corrupt1) - 1);
      @(negedge clk);
      start = 1'b1; addr = t.a; count = t.c;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
      chk(done, {tag_of(v), " done seen"}, done, 1);
      chk(result == t.exp, {tag_of(v), " result"}, result, t.exp);
      if (!t.exp[17] && t.exp != 0) begin
        bad = 0;
        for (int i = 0; i < int'(t.exp); i++)
          if (!mem.exists(int'(t.a) + i) || mem[int'(t.a) + i] != pat(BLK_W'(i))) bad++;
        chk(bad == 0, "R2 R10 content", bad, 0);
      end
      if (t.exp_ff != 8'hFF) begin
        chk(n_ff == int'(t.exp_ff), "R5 read-mode writes", n_ff, t.exp_ff);
        chk(n_70 == int'(t.exp_ff) + int'(t.stuck), "R3 status requests", n_70,
            int'(t.exp_ff) + int'(t.stuck));
      end
      if (t.exp_clr != 8'hFF)
        chk(n_clr == int'(t.exp_clr), (t.errs != 0) ? "R6 clears" : "R4 clears",
            n_clr, t.exp_clr);
      if (t.c == 0)
        chk(n_wr == 0, "R9 no traffic", n_wr, 0);
      @(negedge clk);
      chk(!busy, "R11 idle after run", busy, 0);
    end

    // R11: reset in the middle of a run
    model_init(0, 0, -1);
    @(negedge clk);
    start = 1'b1; addr = 22'h090000; count = 17'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R11 busy mid-run", busy, 1);
    rst_n = 1'b0;
    #1;
    chk(!busy && !src_ready && !fl_wr && !fl_rd, "R11 async reset",
        {busy, src_ready, fl_wr, fl_rd}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R11 idle after reset", {busy, done}, 0);
    summary();
  end
endmodule